// File: doc/BRIEF.md
# Alarm and Update Interrupt Unit

This unit turns the running time of a real-time clock into interrupt requests. It watches the current minute, hour, day of month and weekday, which the clock counters supply. It also receives one-cycle pulses at each second rollover and each minute rollover, plus a one-cycle event from a fixed-cycle timer. Three sources feed three sticky flags: an alarm match, a periodic update tick and the timer event. Each flag has an enable bit. The unit asserts an output-enable for a low-driving open-drain interrupt pin while any enabled flag is set.

Software reaches the alarm settings, a mode register, the flag register and the enable register through a simple byte-wide register port. A write to the port takes effect on the next clock edge, and a read returns data in the same cycle. Each alarm field carries its own "don't care" bit. The day field can hold either a weekday mask or a BCD day of month. The update tick can follow either the second or the minute rollover.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, the three alarm registers (addresses 0, 1, 2) read 0x80, the mode register (3), the flag register (4) and the enable register (5) read 0x00, and `irq_oe` is 0.
- R2: The alarm flag (flag register bit 3) is set only at the clock edge where `min_tick` is 1 and every alarm field that is not ignored matches. Address 0 holds a BCD minute in bits 6:0 and address 1 holds a BCD hour in bits 5:0. With no `min_tick` pulse, a matching time does not set the flag.
- R3: An alarm field whose bit 7 is 1 is left out of the compare. When all three fields are ignored, every `min_tick` pulse sets the alarm flag.
- R4: With mode bit 6 at 1, alarm day bits 5:0 are compared as BCD against `cur_date`. With mode bit 6 at 0, alarm day bits 6:0 are a weekday mask, and the day matches when the mask shares a set bit with the one-hot `cur_wday`.
- R5: Flags are sticky. Writing the flag register clears each flag bit that is written 0. Writing a 1 to a flag bit leaves it unchanged and cannot set it.
- R6: The update flag (flag bit 5) is set by `sec_tick` when mode bit 5 is 0, and by `min_tick` when mode bit 5 is 1. The other pulse does not set it.
- R7: A `tmr_evt` pulse sets the timer flag (flag bit 4).
- R8: `irq_oe` is 1 exactly when some flag is set together with its enable. The enables are enable-register bits 3 (alarm), 4 (timer) and 5 (update). `irq_oe` is released by clearing the flag or the enable.
- R9: When a source event and a clearing write to its flag occur in the same cycle, the flag ends up set.
- R10: The alarm registers read back all 8 bits as written. The mode register reads only bits 6 and 5, and the enable register reads only bits 5:3. All other bits read 0, and addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at each second rollover |
| min_tick | input | 1 | One-cycle pulse at each minute rollover |
| tmr_evt | input | 1 | One-cycle fixed-cycle timer event |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_oe | output | 1 | Drive-low enable for the open-drain interrupt pin |

## Verification
On every cycle, the assertions check the following: a flag rises only after its own source event, and a flag falls only after a clearing write. The alarm flag rises only after a minute rollover, and the update flag follows the selected rollover. An event beats a simultaneous clear, and the interrupt releases only after a register write. The compare itself needs the bench scenarios: which minute, hour, date or weekday values hit, how the ignore bits and the day select change that, the full crossing of flags with enables on `irq_oe`, and the register readback.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int NSRC        = 3;
   localparam int SRC_ALARM   = 0;
   localparam int SRC_TIMER   = 1;
   localparam int SRC_UPDATE  = 2;
   // flag and enable bit of source i sits at SRC_LSB + i
   localparam int SRC_LSB     = 3;
   localparam int MODE_UPD_BIT = 5;
   localparam int MODE_DAY_BIT = 6;
   localparam int ADR_ALM_MIN  = 0;
   localparam int ADR_ALM_HOUR = 1;
   localparam int ADR_ALM_DAY  = 2;
   localparam int ADR_MODE     = 3;
   localparam int ADR_FLAG     = 4;
   localparam int ADR_IEN      = 5;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int MIN_W     = 7,
   parameter int HOUR_W    = 6,
   parameter int DATE_W    = 6,
   parameter int WDAY_N    = 7,
   parameter bit MULTI_DAY = 1'b1
) (
   input  logic [MIN_W-1:0]  alm_min,
   input  logic              ign_min,
   input  logic [HOUR_W-1:0] alm_hour,
   input  logic              ign_hour,
   input  logic [DATE_W-1:0] alm_date,
   input  logic [WDAY_N-1:0] alm_wday,
   input  logic              ign_day,
   input  logic              day_is_date,
   input  logic [MIN_W-1:0]  cur_min,
   input  logic [HOUR_W-1:0] cur_hour,
   input  logic [DATE_W-1:0] cur_date,
   input  logic [WDAY_N-1:0] cur_wday,
   output logic              hit
);
   logic min_ok, hour_ok, day_ok, wday_eq;

   generate
      if (MULTI_DAY) begin : g_wday_mask
         assign wday_eq = |(alm_wday & cur_wday);
      end else begin : g_wday_exact
         assign wday_eq = (alm_wday == cur_wday);
      end
   endgenerate

   always_comb begin
      min_ok  = ign_min  | (alm_min  == cur_min);
      hour_ok = ign_hour | (alm_hour == cur_hour);
      day_ok  = ign_day  | (day_is_date ? (alm_date == cur_date) : wday_eq);
      hit     = min_ok & hour_ok & day_ok;
   end
endmodule

// File: rtl/rtc_irq_src.sv
module rtc_irq_src #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic req
);
   logic flag_q, flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb flag_d = evt ? 1'b1 : (clr ? 1'b0 : flag_q);
      end else begin : g_clr_first
         always_comb flag_d = clr ? 1'b0 : (evt ? 1'b1 : flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;
   assign req  = flag_q & en;

   AST_FLAG_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(evt)); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr)); // R5

   generate
      if (SET_WINS) begin : g_chk_set
         AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            evt |=> flag_q); // R9
      end
   endgenerate
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int MIN_W     = 7,
   parameter int HOUR_W    = 6,
   parameter int DATE_W    = 6,
   parameter int WDAY_N    = 7,
   parameter bit MULTI_DAY = 1'b1,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              min_tick,
   input  logic              tmr_evt,
   input  logic [MIN_W-1:0]  cur_min,
   input  logic [HOUR_W-1:0] cur_hour,
   input  logic [DATE_W-1:0] cur_date,
   input  logic [WDAY_N-1:0] cur_wday,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_oe
);
   localparam int IGN_BIT = DATA_W - 1;
   localparam logic [DATA_W-1:0] ALM_RST = DATA_W'(1) << IGN_BIT;

   generate
      if (IGN_BIT <= MODE_DAY_BIT) begin : g_bad_data_w
         $error("DATA_W too small for the mode and ignore bits");
      end
      if (SRC_LSB + NSRC > MODE_DAY_BIT + 1) begin : g_bad_src
         $error("source bits overlap");
      end
      if (MIN_W > IGN_BIT || HOUR_W > IGN_BIT || DATE_W > IGN_BIT || WDAY_N > IGN_BIT) begin : g_bad_field
         $error("time field wider than alarm register payload");
      end
      if ((1 << ADDR_W) <= ADR_IEN) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [DATA_W-1:0] alm_min_q, alm_hour_q, alm_day_q;
   logic              day_sel_q, upd_sel_q;
   logic [NSRC-1:0]   ien_q;
   logic [NSRC-1:0]   evt_w, clr_w, flag_w, req_w;
   logic              alarm_hit;
   logic              wr_min, wr_hour, wr_day, wr_mode, wr_flag, wr_ien;

   always_comb begin
      wr_min  = reg_we && (reg_addr == ADDR_W'(ADR_ALM_MIN));
      wr_hour = reg_we && (reg_addr == ADDR_W'(ADR_ALM_HOUR));
      wr_day  = reg_we && (reg_addr == ADDR_W'(ADR_ALM_DAY));
      wr_mode = reg_we && (reg_addr == ADDR_W'(ADR_MODE));
      wr_flag = reg_we && (reg_addr == ADDR_W'(ADR_FLAG));
      wr_ien  = reg_we && (reg_addr == ADDR_W'(ADR_IEN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_min_q  <= ALM_RST;
         alm_hour_q <= ALM_RST;
         alm_day_q  <= ALM_RST;
         day_sel_q  <= 1'b0;
         upd_sel_q  <= 1'b0;
         ien_q      <= '0;
      end else begin
         if (wr_min)  alm_min_q  <= reg_wdata;
         if (wr_hour) alm_hour_q <= reg_wdata;
         if (wr_day)  alm_day_q  <= reg_wdata;
         if (wr_mode) begin
            day_sel_q <= reg_wdata[MODE_DAY_BIT];
            upd_sel_q <= reg_wdata[MODE_UPD_BIT];
         end
         if (wr_ien) ien_q <= reg_wdata[SRC_LSB +: NSRC];
      end
   end

   rtc_alarm_cmp #(
      .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DATE_W(DATE_W),
      .WDAY_N(WDAY_N), .MULTI_DAY(MULTI_DAY)
   ) u_cmp (
      .alm_min     (alm_min_q[MIN_W-1:0]),
      .ign_min     (alm_min_q[IGN_BIT]),
      .alm_hour    (alm_hour_q[HOUR_W-1:0]),
      .ign_hour    (alm_hour_q[IGN_BIT]),
      .alm_date    (alm_day_q[DATE_W-1:0]),
      .alm_wday    (alm_day_q[WDAY_N-1:0]),
      .ign_day     (alm_day_q[IGN_BIT]),
      .day_is_date (day_sel_q),
      .cur_min     (cur_min),
      .cur_hour    (cur_hour),
      .cur_date    (cur_date),
      .cur_wday    (cur_wday),
      .hit         (alarm_hit)
   );

   always_comb begin
      evt_w[SRC_ALARM]  = min_tick & alarm_hit;
      evt_w[SRC_TIMER]  = tmr_evt;
      evt_w[SRC_UPDATE] = upd_sel_q ? min_tick : sec_tick;
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign clr_w[i] = wr_flag & ~reg_wdata[SRC_LSB + i];
         rtc_irq_src #(.SET_WINS(SET_WINS)) u_src (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt_w[i]),
            .clr  (clr_w[i]),
            .en   (ien_q[i]),
            .flag (flag_w[i]),
            .req  (req_w[i])
         );
      end
   endgenerate

   assign irq_oe = |req_w;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_ALM_MIN))       reg_rdata = alm_min_q;
      else if (reg_addr == ADDR_W'(ADR_ALM_HOUR)) reg_rdata = alm_hour_q;
      else if (reg_addr == ADDR_W'(ADR_ALM_DAY))  reg_rdata = alm_day_q;
      else if (reg_addr == ADDR_W'(ADR_MODE)) begin
         reg_rdata[MODE_DAY_BIT] = day_sel_q;
         reg_rdata[MODE_UPD_BIT] = upd_sel_q;
      end
      else if (reg_addr == ADDR_W'(ADR_FLAG)) reg_rdata[SRC_LSB +: NSRC] = flag_w;
      else if (reg_addr == ADDR_W'(ADR_IEN))  reg_rdata[SRC_LSB +: NSRC] = ien_q;
   end

   AST_ALARM_ON_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_w[SRC_ALARM]) |-> $past(min_tick)); // R2
   AST_UPDATE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_w[SRC_UPDATE]) |-> $past(upd_sel_q ? min_tick : sec_tick)); // R6
   AST_IRQ_RELEASE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_oe) |-> $past(reg_we)); // R8
endmodule

// File: tb/rtc_irq_unit_test.sv
`timescale 1ns/1ps
module rtc_irq_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0, min_tick = 1'b0, tmr_evt = 1'b0;
   logic [6:0] cur_min = '0;
   logic [5:0] cur_hour = '0;
   logic [5:0] cur_date = 6'h01;
   logic [6:0] cur_wday = 7'b0000001;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_oe;
   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rtc_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
      .tmr_evt(tmr_evt), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_date(cur_date), .cur_wday(cur_wday), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_oe(irq_oe)
   );

   function automatic logic [7:0] bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 3'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input bit s, input bit m, input bit t);
      @(negedge clk);
      sec_tick = s; min_tick = m; tmr_evt = t;
      @(negedge clk);
      sec_tick = 1'b0; min_tick = 1'b0; tmr_evt = 1'b0;
   endtask

   task automatic flag_bit(input int b, input bit exp, input string req);
      logic [7:0] v;
      rd(4, v);
      check(req, {7'b0, v[b]}, {7'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values, R10 unused addresses
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         check(a < 3 ? "R1" : (a < 6 ? "R1" : "R10"), v, (a < 3) ? 8'h80 : 8'h00);
      end
      check("R1 irq", {7'b0, irq_oe}, 8'h00);

      // R10 readback masks
      wr(0, 8'h5A); rd(0, v); check("R10", v, 8'h5A);
      wr(1, 8'hA5); rd(1, v); check("R10", v, 8'hA5);
      wr(2, 8'h3C); rd(2, v); check("R10", v, 8'h3C);
      wr(3, 8'hFF); rd(3, v); check("R10", v, 8'h60);
      wr(5, 8'hFF); rd(5, v); check("R10", v, 8'h38);
      wr(4, 8'hFF); rd(4, v); check("R10 R5 no set", v, 8'h00);
      wr(3, 8'h00); wr(5, 8'h00);

      // R2 minute sweep
      wr(0, bcd(23)); wr(1, 8'h80); wr(2, 8'h80);
      cur_min = 7'(bcd(23));
      repeat (3) @(negedge clk);
      flag_bit(3, 1'b0, "R2 no tick");
      for (int m = 0; m < 60; m++) begin
         cur_min = 7'(bcd(m));
         pulse(0, 1, 0);
         flag_bit(3, (m == 23), "R2 minute");
         wr(4, 8'h00);
      end

      // R3 ignore bits crossed with single-field mismatches (date mode)
      wr(3, 8'h40);
      for (int k = 0; k < 8; k++) begin
         wr(0, bcd(10) | (k[0] ? 8'h80 : 8'h00));
         wr(1, bcd(5)  | (k[1] ? 8'h80 : 8'h00));
         wr(2, bcd(12) | (k[2] ? 8'h80 : 8'h00));
         for (int f = 0; f < 4; f++) begin
            cur_min  = 7'(bcd(f == 0 ? 11 : 10));
            cur_hour = 6'(bcd(f == 1 ? 6 : 5));
            cur_date = 6'(bcd(f == 2 ? 13 : 12));
            pulse(0, 1, 0);
            flag_bit(3, (f == 3) ? 1'b1 : k[f], "R3 ignore");
            wr(4, 8'h00);
         end
      end

      // R4 date compare
      wr(0, 8'h80); wr(1, 8'h80); wr(2, bcd(17));
      for (int d = 1; d < 32; d++) begin
         cur_date = 6'(bcd(d));
         pulse(0, 1, 0);
         flag_bit(3, (d == 17), "R4 date");
         wr(4, 8'h00);
      end

      // R4 weekday mask
      wr(3, 8'h00); wr(2, 8'h25);
      for (int w = 0; w < 7; w++) begin
         cur_wday = 7'(1 << w);
         cur_date = 6'(bcd(w + 1));
         pulse(0, 1, 0);
         flag_bit(3, (w == 0 || w == 2 || w == 5), "R4 weekday");
         wr(4, 8'h00);
      end

      // R6 update source select
      wr(2, 8'h80);
      pulse(1, 0, 0); flag_bit(5, 1'b1, "R6 sec sets");
      wr(4, 8'h00);
      pulse(0, 1, 0); flag_bit(5, 1'b0, "R6 min ignored");
      wr(4, 8'h00);
      wr(3, 8'h20);
      pulse(1, 0, 0); flag_bit(5, 1'b0, "R6 sec ignored");
      pulse(0, 1, 0); flag_bit(5, 1'b1, "R6 min sets");
      wr(4, 8'h00); wr(3, 8'h00);

      // R7 timer flag
      flag_bit(4, 1'b0, "R7 idle");
      pulse(0, 0, 1); flag_bit(4, 1'b1, "R7 event");

      // R5 sticky and selective clear
      pulse(1, 1, 0);
      rd(4, v); check("R5 all set", v, 8'h38);
      wr(4, 8'hFF); rd(4, v); check("R5 write one keeps", v, 8'h38);
      repeat (4) @(negedge clk);
      rd(4, v); check("R5 sticky", v, 8'h38);
      wr(4, 8'hF7); rd(4, v); check("R5 clear alarm only", v, 8'h30);
      wr(4, 8'h00); rd(4, v); check("R5 clear all", v, 8'h00);

      // R8 every flag pattern against every enable pattern
      for (int f = 0; f < 8; f++) begin
         for (int e = 0; e < 8; e++) begin
            wr(4, 8'h00);
            wr(5, 8'(e << 3));
            pulse(f[2], f[0], f[1]);
            @(negedge clk);
            check("R8 irq", {7'b0, irq_oe}, {7'b0, |(f & e)});
         end
      end
      // R8 release paths
      wr(4, 8'h00); wr(5, 8'h08);
      pulse(0, 1, 0);
      check("R8 asserted", {7'b0, irq_oe}, 8'h01);
      wr(5, 8'h00);
      check("R8 released by enable", {7'b0, irq_oe}, 8'h00);
      wr(5, 8'h08);
      check("R8 reasserted", {7'b0, irq_oe}, 8'h01);
      wr(4, 8'h00);
      check("R8 released by clear", {7'b0, irq_oe}, 8'h00);

      // R9 event and clear in the same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
      min_tick = 1'b1; tmr_evt = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; min_tick = 1'b0; tmr_evt = 1'b0;
      flag_bit(3, 1'b1, "R9 alarm");
      flag_bit(4, 1'b1, "R9 timer");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule